// File: doc/BRIEF.md
# Warp Issue Buffer with Register-Id Scoreboard

This block sits between instruction fetch and operand collection in a multi-warp SIMT core. Each warp owns a small in-order instruction queue and a scoreboard of a few slots. Each slot records the id of a destination register whose write has not completed. Fetched instructions arrive tagged with a warp number, a destination register and two source registers, plus an opaque tag that is carried through unchanged. Writeback events name a warp and a register, and they release the matching scoreboard slot.

Each cycle the block looks only at the oldest instruction of every warp. A head is eligible when none of its register operands matches a live slot in its warp's scoreboard. If the head writes a register, a free slot must also exist for it. Among eligible warps one is granted in rotating order and presented on a valid/ready issue port. When the issue is accepted, the head is removed and its destination is recorded in a free slot. A per-warp stall vector tells fetch which queues cannot take more instructions. Register 0 is a constant: it never causes a hazard and is never recorded.

Top module: `sbib_top`

## Requirements
- R1: While and directly after reset, `issue_valid` is 0 and every bit of `fetch_stall` is 0.
- R2: Instructions of one warp leave in the order they were accepted. The issue port shows the oldest queued instruction of the granted warp: its warp number, destination, both sources and tag.
- R3: `fetch_stall[w]` is 1 exactly when warp w's queue holds `BUF_DEPTH` instructions. A fetch to a warp whose stall bit is 1 is discarded and never issues.
- R4: A head whose nonzero source register matches a pending register of its warp is not issued until a writeback for that warp and register arrives.
- R5: A head whose nonzero destination register is already pending in its warp is not issued until that register is written back.
- R6: When a warp already has `SB_ENTRIES` pending registers, a head with a nonzero destination waits even without any hazard. A head with destination 0 still issues.
- R7: Register id 0 is never reserved and never matched. Instructions naming only register 0 issue back to back, and a writeback of register 0 changes nothing.
- R8: A writeback arriving in the same cycle as the hazard check releases its register for that check, so a head waiting only on that register is offered in that very cycle.
- R9: The granted warp is the first eligible one in increasing warp order, counting from the warp after the one that last issued and wrapping around. After reset, warp 0 is searched first.
- R10: A head is removed and its destination reserved only in a cycle with `issue_valid` and `issue_ready` both 1. While `issue_ready` is 0, the queues only fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | A fetched instruction is presented |
| fetch_warp | input | $clog2(NUM_WARPS) | Warp of the fetched instruction |
| fetch_dst | input | REG_W | Destination register id |
| fetch_src0 | input | REG_W | First source register id |
| fetch_src1 | input | REG_W | Second source register id |
| fetch_tag | input | TAG_W | Opaque payload carried to issue |
| fetch_stall | output | NUM_WARPS | Per-warp queue full; fetch to that warp is dropped |
| wb_valid | input | 1 | A register write has completed |
| wb_warp | input | $clog2(NUM_WARPS) | Warp of the completed write |
| wb_reg | input | REG_W | Register id of the completed write |
| issue_valid | output | 1 | An eligible instruction is offered |
| issue_ready | input | 1 | Downstream accepts the offered instruction |
| issue_warp | output | $clog2(NUM_WARPS) | Warp of the offered instruction |
| issue_dst | output | REG_W | Destination of the offered instruction |
| issue_src0 | output | REG_W | First source of the offered instruction |
| issue_src1 | output | REG_W | Second source of the offered instruction |
| issue_tag | output | TAG_W | Payload of the offered instruction |

## Verification
The issue port is combinational from the queue heads, the scoreboards and the same-cycle writeback, so its values are due in the same cycle as the inputs. The bench drives inputs at the falling edge and compares the issue port 1 ns later, before the rising edge that commits the handshake. An accepted fetch, a removed head or a new reservation shows up one rising edge later, including on `fetch_stall`. The bench's reference queues and pending-register sets are advanced only after that edge, so each compare reflects exactly the state the design holds in that cycle.

// File: rtl/sbib_pkg.sv
package sbib_pkg;

   // Next index in a ring of n positions, starting after 'cur' by 'step'.
   function automatic int ring_pos(input int cur, input int step, input int n);
      return (cur + step) % n;
   endfunction

endpackage

// File: rtl/sbib_fifo.sv
module sbib_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   generate
      if (DEPTH == 1) begin : g_single
         logic         held;
         logic [W-1:0] word;
         always_ff @(posedge clk) begin
            if (!rst_n)    held <= 1'b0;
            else if (push) held <= 1'b1;
            else if (pop)  held <= 1'b0;
         end
         always_ff @(posedge clk) begin
            if (push) word <= din;
         end
         assign dout  = word;
         assign full  = held;
         assign empty = !held;
      end else begin : g_ring
         localparam int PTR_W = $clog2(DEPTH);
         localparam int CNT_W = $clog2(DEPTH + 1);
         logic [W-1:0]     mem [DEPTH];
         logic [PTR_W-1:0] wp, rp;
         logic [CNT_W-1:0] cnt;

         function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
            return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
         endfunction

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wp  <= '0;
               rp  <= '0;
               cnt <= '0;
            end else begin
               if (push) wp <= bump(wp);
               if (pop)  rp <= bump(rp);
               cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
            end
         end
         always_ff @(posedge clk) begin
            if (push) mem[wp] <= din;
         end
         assign dout  = mem[rp];
         assign full  = (cnt == CNT_W'(DEPTH));
         assign empty = (cnt == '0);
      end
   endgenerate
endmodule

// File: rtl/sbib_scoreboard.sv
module sbib_scoreboard #(
   parameter int ENTRIES = 4,
   parameter int REG_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_en,
   input  logic [REG_W-1:0] clr_reg,
   input  logic [REG_W-1:0] q_dst,
   input  logic [REG_W-1:0] q_src0,
   input  logic [REG_W-1:0] q_src1,
   input  logic             set_en,
   output logic             hazard,
   output logic             no_room
);
   logic [ENTRIES-1:0] vld, vld_eff, vld_nxt, free_oh;
   logic [ENTRIES-1:0] hit_d, hit_a, hit_b;
   logic [REG_W-1:0]   slot_id [ENTRIES];
   logic               seen;

   always_comb begin
      free_oh = '0;
      seen    = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         // a completing write frees its slot before the hazard check
         vld_eff[i] = vld[i] & ~(clr_en && slot_id[i] == clr_reg);
         hit_d[i]   = vld_eff[i] && slot_id[i] == q_dst;
         hit_a[i]   = vld_eff[i] && slot_id[i] == q_src0;
         hit_b[i]   = vld_eff[i] && slot_id[i] == q_src1;
         if (!vld_eff[i] && !seen) begin
            free_oh[i] = 1'b1;
            seen       = 1'b1;
         end
      end
      hazard  = (q_dst  != '0 && |hit_d) ||
                (q_src0 != '0 && |hit_a) ||
                (q_src1 != '0 && |hit_b);
      no_room = &vld_eff;
      vld_nxt = vld_eff | (set_en ? free_oh : '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) vld <= '0;
      else        vld <= vld_nxt;
   end

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)                      slot_id[i] <= '0;
         else if (set_en && free_oh[i])   slot_id[i] <= q_dst;
      end
   end
endmodule

// File: rtl/sbib_rr_arb.sv
module sbib_rr_arb #(
   parameter int  N     = 4,
   localparam int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   input  logic             advance,
   output logic             gnt_valid,
   output logic [IDX_W-1:0] gnt_idx
);
   logic [IDX_W-1:0] last;
   int               cand;

   always_comb begin
      gnt_valid = 1'b0;
      gnt_idx   = '0;
      cand      = 0;
      for (int k = 1; k <= N; k++) begin
         cand = sbib_pkg::ring_pos(int'(last), k, N);
         if (!gnt_valid && req[cand]) begin
            gnt_valid = 1'b1;
            gnt_idx   = IDX_W'(cand);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       last <= IDX_W'(N - 1);
      else if (advance) last <= gnt_idx;
   end
endmodule

// File: rtl/sbib_top.sv
module sbib_top #(
   parameter int  NUM_WARPS  = 4,
   parameter int  BUF_DEPTH  = 4,
   parameter int  SB_ENTRIES = 4,
   parameter int  REG_W      = 5,
   parameter int  TAG_W      = 8,
   localparam int WARP_W     = $clog2(NUM_WARPS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fetch_valid,
   input  logic [WARP_W-1:0]    fetch_warp,
   input  logic [REG_W-1:0]     fetch_dst,
   input  logic [REG_W-1:0]     fetch_src0,
   input  logic [REG_W-1:0]     fetch_src1,
   input  logic [TAG_W-1:0]     fetch_tag,
   output logic [NUM_WARPS-1:0] fetch_stall,
   input  logic                 wb_valid,
   input  logic [WARP_W-1:0]    wb_warp,
   input  logic [REG_W-1:0]     wb_reg,
   output logic                 issue_valid,
   input  logic                 issue_ready,
   output logic [WARP_W-1:0]    issue_warp,
   output logic [REG_W-1:0]     issue_dst,
   output logic [REG_W-1:0]     issue_src0,
   output logic [REG_W-1:0]     issue_src1,
   output logic [TAG_W-1:0]     issue_tag
);
   localparam int INS_W = TAG_W + 3 * REG_W;

   if (NUM_WARPS < 2)                      begin : g_bad_warps $error("NUM_WARPS must be at least 2"); end
   if (BUF_DEPTH < 1)                      begin : g_bad_depth $error("BUF_DEPTH must be at least 1"); end
   if (SB_ENTRIES < 1 || SB_ENTRIES > 8)   begin : g_bad_sb    $error("SB_ENTRIES must be 1..8"); end
   if (REG_W < 2)                          begin : g_bad_reg   $error("REG_W must be at least 2"); end

   logic [INS_W-1:0]     fetch_word;
   logic [INS_W-1:0]     head  [NUM_WARPS];
   logic [REG_W-1:0]     h_dst [NUM_WARPS];
   logic [REG_W-1:0]     h_s0  [NUM_WARPS];
   logic [REG_W-1:0]     h_s1  [NUM_WARPS];
   logic [TAG_W-1:0]     h_tag [NUM_WARPS];
   logic [NUM_WARPS-1:0] push, pop, full, empty, hz, nr, elig;
   logic                 gnt_valid, fire;
   logic [WARP_W-1:0]    gnt_idx;

   assign fetch_word = {fetch_tag, fetch_src1, fetch_src0, fetch_dst};
   assign fire       = gnt_valid && issue_ready;

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
      assign push[w] = fetch_valid && fetch_warp == WARP_W'(w) && !full[w];
      assign pop[w]  = fire && gnt_idx == WARP_W'(w);

      sbib_fifo #(.DEPTH(BUF_DEPTH), .W(INS_W)) u_buf (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (push[w]),
         .din   (fetch_word),
         .pop   (pop[w]),
         .dout  (head[w]),
         .full  (full[w]),
         .empty (empty[w])
      );

      assign h_dst[w] = head[w][REG_W-1:0];
      assign h_s0[w]  = head[w][2*REG_W-1:REG_W];
      assign h_s1[w]  = head[w][3*REG_W-1:2*REG_W];
      assign h_tag[w] = head[w][INS_W-1:3*REG_W];

      sbib_scoreboard #(.ENTRIES(SB_ENTRIES), .REG_W(REG_W)) u_sb (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr_en  (wb_valid && wb_warp == WARP_W'(w)),
         .clr_reg (wb_reg),
         .q_dst   (h_dst[w]),
         .q_src0  (h_s0[w]),
         .q_src1  (h_s1[w]),
         .set_en  (pop[w] && h_dst[w] != '0),
         .hazard  (hz[w]),
         .no_room (nr[w])
      );

      assign elig[w] = !empty[w] && !hz[w] && !(h_dst[w] != '0 && nr[w]);
   end

   sbib_rr_arb #(.N(NUM_WARPS)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (elig),
      .advance   (fire),
      .gnt_valid (gnt_valid),
      .gnt_idx   (gnt_idx)
   );

   assign fetch_stall = full;
   assign issue_valid = gnt_valid;
   assign issue_warp  = gnt_idx;
   assign issue_dst   = h_dst[gnt_idx];
   assign issue_src0  = h_s0[gnt_idx];
   assign issue_src1  = h_s1[gnt_idx];
   assign issue_tag   = h_tag[gnt_idx];
endmodule

// File: rtl/sbib_chk.sv
module sbib_chk #(
   parameter int  NUM_WARPS  = 4,
   parameter int  BUF_DEPTH  = 4,
   parameter int  SB_ENTRIES = 4,
   parameter int  REG_W      = 5,
   localparam int WARP_W     = $clog2(NUM_WARPS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 fetch_valid,
   input logic [WARP_W-1:0]    fetch_warp,
   input logic [NUM_WARPS-1:0] fetch_stall,
   input logic                 wb_valid,
   input logic [WARP_W-1:0]    wb_warp,
   input logic [REG_W-1:0]     wb_reg,
   input logic                 issue_valid,
   input logic                 issue_ready,
   input logic [WARP_W-1:0]    issue_warp,
   input logic [REG_W-1:0]     issue_dst,
   input logic [REG_W-1:0]     issue_src0,
   input logic [REG_W-1:0]     issue_src1
);
   localparam int NREG = 1 << REG_W;

   logic [NREG-1:0] pend [NUM_WARPS];
   logic [NREG-1:0] pe   [NUM_WARPS];
   int              occ  [NUM_WARPS];
   logic            fire;

   assign fire = issue_valid && issue_ready;

   always_comb begin
      for (int w = 0; w < NUM_WARPS; w++) begin
         pe[w] = pend[w];
         if (wb_valid && wb_warp == WARP_W'(w)) pe[w][wb_reg] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      for (int w = 0; w < NUM_WARPS; w++) begin
         if (!rst_n) begin
            pend[w] <= '0;
            occ[w]  <= 0;
         end else begin
            pend[w] <= pe[w] | ((fire && issue_warp == WARP_W'(w) && issue_dst != '0)
                                ? (NREG'(1) << issue_dst) : '0);
            occ[w]  <= occ[w]
                       + ((fetch_valid && fetch_warp == WARP_W'(w) && !fetch_stall[w]) ? 1 : 0)
                       - ((fire && issue_warp == WARP_W'(w)) ? 1 : 0);
         end
      end
   end

   // R1: idle outputs in the first cycle out of reset
   p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!issue_valid && fetch_stall == '0));

   for (genvar g = 0; g < NUM_WARPS; g++) begin : g_chk
      // R3: stall tracks the occupancy seen at the ports
      p_occ_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
         fetch_stall[g] == (occ[g] == BUF_DEPTH));

      // R4: no offered source is still pending
      p_raw_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (issue_valid && issue_warp == WARP_W'(g)) |->
            !((issue_src0 != '0 && pe[g][issue_src0]) ||
              (issue_src1 != '0 && pe[g][issue_src1])));

      // R5: no offered destination is still pending
      p_waw_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (issue_valid && issue_warp == WARP_W'(g) && issue_dst != '0) |->
            !pe[g][issue_dst]);

      // R6: a reservation is offered only when a slot is free
      p_sb_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (issue_valid && issue_warp == WARP_W'(g) && issue_dst != '0) |->
            ($countones(pe[g][NREG-1:1]) < SB_ENTRIES));

      // R2: an offer from warp g implies warp g holds an instruction
      p_offer_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (issue_valid && issue_warp == WARP_W'(g)) |-> (occ[g] > 0));
   end
endmodule

bind sbib_top sbib_chk #(
   .NUM_WARPS  (NUM_WARPS),
   .BUF_DEPTH  (BUF_DEPTH),
   .SB_ENTRIES (SB_ENTRIES),
   .REG_W      (REG_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fetch_valid (fetch_valid),
   .fetch_warp  (fetch_warp),
   .fetch_stall (fetch_stall),
   .wb_valid    (wb_valid),
   .wb_warp     (wb_warp),
   .wb_reg      (wb_reg),
   .issue_valid (issue_valid),
   .issue_ready (issue_ready),
   .issue_warp  (issue_warp),
   .issue_dst   (issue_dst),
   .issue_src0  (issue_src0),
   .issue_src1  (issue_src1)
);

// File: tb/sim_sbib_top.sv
module sim_sbib_top;
   localparam int NW = 4;
   localparam int DP = 4;
   localparam int SB = 4;

   typedef struct packed {
      logic [7:0] tag;
      logic [4:0] s1;
      logic [4:0] s0;
      logic [4:0] dst;
   } ins_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fetch_valid = 1'b0;
   logic [1:0]    fetch_warp = '0;
   logic [4:0]    fetch_dst = '0, fetch_src0 = '0, fetch_src1 = '0;
   logic [7:0]    fetch_tag = '0;
   logic [NW-1:0] fetch_stall;
   logic          wb_valid = 1'b0;
   logic [1:0]    wb_warp = '0;
   logic [4:0]    wb_reg = '0;
   logic          issue_valid;
   logic          issue_ready = 1'b0;
   logic [1:0]    issue_warp;
   logic [4:0]    issue_dst, issue_src0, issue_src1;
   logic [7:0]    issue_tag;

   int   checks = 0, fails = 0;
   bit   done = 0;
   int   tagc = 1;

   ins_t      mq   [NW][DP];
   int        mcnt [NW];
   bit [31:0] mpend[NW];
   int        mlast = NW - 1;

   always #4 clk = ~clk;

   sbib_top #(.NUM_WARPS(NW), .BUF_DEPTH(DP), .SB_ENTRIES(SB), .REG_W(5), .TAG_W(8)) u0 (
      .clk(clk), .rst_n(rst_n),
      .fetch_valid(fetch_valid), .fetch_warp(fetch_warp), .fetch_dst(fetch_dst),
      .fetch_src0(fetch_src0), .fetch_src1(fetch_src1), .fetch_tag(fetch_tag),
      .fetch_stall(fetch_stall),
      .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
      .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_warp(issue_warp),
      .issue_dst(issue_dst), .issue_src0(issue_src0), .issue_src1(issue_src1),
      .issue_tag(issue_tag)
   );

   function automatic bit m_elig(input int w);
      bit [31:0] pe;
      ins_t h;
      if (mcnt[w] == 0) return 0;
      h  = mq[w][0];
      pe = mpend[w];
      if (wb_valid && int'(wb_warp) == w) pe[wb_reg] = 1'b0;
      pe[0] = 1'b0;
      if (h.s0  != 0 && pe[h.s0])  return 0;
      if (h.s1  != 0 && pe[h.s1])  return 0;
      if (h.dst != 0 && pe[h.dst]) return 0;
      if (h.dst != 0 && $countones(pe) >= SB) return 0;
      return 1;
   endfunction

   function automatic int m_pick();
      for (int k = 1; k <= NW; k++) begin
         if (m_elig((mlast + k) % NW)) return (mlast + k) % NW;
      end
      return -1;
   endfunction

   task automatic cmp(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic cyc(input string req);
      int   pick;
      bit   acc;
      ins_t h;
      logic [NW-1:0] xs;
      #1;
      pick = m_pick();
      for (int w = 0; w < NW; w++) xs[w] = (mcnt[w] == DP);
      cmp(req, "issue_valid", 64'(issue_valid), 64'(pick >= 0));
      cmp(req, "fetch_stall", 64'(fetch_stall), 64'(xs));
      if (pick >= 0 && issue_valid) begin
         h = mq[pick][0];
         cmp(req, "issue fields", {issue_warp, issue_dst, issue_src0, issue_src1, issue_tag},
             {2'(pick), h.dst, h.s0, h.s1, h.tag});
      end
      acc = fetch_valid && mcnt[fetch_warp] < DP;
      @(posedge clk);
      if (wb_valid) mpend[wb_warp][wb_reg] = 1'b0;
      if (pick >= 0 && issue_ready) begin
         h = mq[pick][0];
         for (int i = 0; i < DP - 1; i++) mq[pick][i] = mq[pick][i+1];
         mcnt[pick]--;
         if (h.dst != 0) mpend[pick][h.dst] = 1'b1;
         mlast = pick;
      end
      if (acc) begin
         mq[fetch_warp][mcnt[fetch_warp]] = {fetch_tag, fetch_src1, fetch_src0, fetch_dst};
         mcnt[fetch_warp]++;
      end
      @(negedge clk);
   endtask

   task automatic fetch(input int w, input int d, input int a, input int b);
      fetch_valid = 1'b1;
      fetch_warp  = 2'(w);
      fetch_dst   = 5'(d);
      fetch_src0  = 5'(a);
      fetch_src1  = 5'(b);
      fetch_tag   = 8'(tagc);
      tagc++;
   endtask

   task automatic quiet();
      fetch_valid = 1'b0;
      wb_valid    = 1'b0;
   endtask

   task automatic wb(input int w, input int r);
      wb_valid = 1'b1;
      wb_warp  = 2'(w);
      wb_reg   = 5'(r);
   endtask

   task automatic clear_all(input string req);
      issue_ready = 1'b1;
      fetch_valid = 1'b0;
      for (int w = 0; w < NW; w++)
         for (int r = 0; r < 8; r++) begin
            wb(w, r);
            cyc(req);
         end
      quiet();
      repeat (DP * NW) cyc(req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int w = 0; w < NW; w++) begin mcnt[w] = 0; mpend[w] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc("R1");
      cyc("R1");

      // R3 / R10: fill warp 0 with ready low, fifth fetch dropped
      issue_ready = 1'b0;
      for (int i = 0; i < 5; i++) begin fetch(0, 0, 0, 0); cyc("R3"); end
      quiet();
      cyc("R10");
      // R2: drain in order
      issue_ready = 1'b1;
      repeat (6) cyc("R2");

      // R4 then R8: source waits for writeback, same-cycle release
      issue_ready = 1'b0;
      fetch(1, 3, 0, 0); cyc("R4");
      fetch(1, 0, 3, 0); cyc("R4");
      quiet(); issue_ready = 1'b1;
      cyc("R4"); cyc("R4"); cyc("R4");
      wb(1, 3); cyc("R8");
      quiet(); cyc("R8");

      // R5: destination already pending
      fetch(1, 5, 0, 0); cyc("R5");
      fetch(1, 5, 1, 2); cyc("R5");
      quiet(); cyc("R5"); cyc("R5");
      wb(1, 5); cyc("R5");
      quiet(); cyc("R5");
      clear_all("R5");

      // R6: slot capacity
      for (int d = 1; d <= 4; d++) begin fetch(2, d, 0, 0); cyc("R6"); end
      fetch(2, 0, 6, 0); cyc("R6");
      fetch(2, 5, 0, 0); cyc("R6");
      quiet();
      repeat (3) cyc("R6");
      wb(2, 1); cyc("R6");
      quiet(); cyc("R6");
      clear_all("R6");

      // R7: register 0 never blocks, writeback of 0 is harmless
      issue_ready = 1'b0;
      fetch(3, 0, 0, 0); cyc("R7");
      fetch(3, 0, 0, 0); cyc("R7");
      fetch(3, 7, 0, 0); cyc("R7");
      quiet(); issue_ready = 1'b1;
      wb(3, 0); cyc("R7");
      quiet(); repeat (3) cyc("R7");
      clear_all("R7");

      // R9: rotating grant over all warps
      issue_ready = 1'b0;
      for (int w = 0; w < NW; w++) begin fetch(w, 0, 0, 0); cyc("R9"); end
      for (int w = 0; w < NW; w++) begin fetch(w, 0, 0, 0); cyc("R9"); end
      quiet(); issue_ready = 1'b1;
      repeat (10) cyc("R9");

      // constrained random mix
      for (int n = 0; n < 3000; n++) begin
         if ($urandom % 4 != 0) fetch($urandom % NW, $urandom % 8, $urandom % 8, $urandom % 8);
         else fetch_valid = 1'b0;
         if ($urandom % 2 == 0) wb($urandom % NW, $urandom % 8);
         else wb_valid = 1'b0;
         issue_ready = ($urandom % 4 != 0);
         cyc("R2 R4 R5 R6 R9");
      end
      clear_all("R2");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule